// File: doc/BRIEF.md
# Passive SPI Bus Monitor Framer

This block listens to an existing SPI bus and turns the traffic into a byte stream for a host link. The clock, chip-select and both data lines of the bus are inputs only. The block has no output that touches the bus, so attaching it never loads or holds a bus line, whether it is capturing or idle. The bus signals are brought into the system clock domain through flop synchronisers. The system clock must run at least four times faster than the bus clock.

Byte framing starts only when the block sees chip-select fall while it is enabled. The chip-select level alone never starts a frame. A monitor attached in the middle of a transfer therefore stays silent until the next chip-select cycle. Every such cycle clears the bit count and both shift registers, so byte boundaries cannot stay misaligned. Each completed word yields one bus-out byte and one bus-in byte.

The pair leaves on a ready/valid stream in one of two formats. The verbose format adds parentheses around the bus-in byte. The compact format sends the two raw bytes, which halves the stream bandwidth.

Top module: `spi_sniff_framer`

## Requirements
- R1: After reset, out_valid_o, short_o and overrun_o are all 0.
- R2: A frame is armed only by a chip-select high-to-low edge seen while en_i is 1. If chip-select is already low when enabling, no byte is reported until chip-select goes high and then low again.
- R3: Each chip-select assertion clears the bit count and both shift registers, so a full byte that follows an aborted partial byte is reported with correct values.
- R4: If chip-select rises in an armed frame after 1 to 7 bits, the partial byte is dropped and short_o is set. short_o stays 1 until clr_i is 1.
- R5: cpol_i gives the clock idle level. When cpha_i is 0, bits are sampled on the idle-to-active clock edge. When cpha_i is 1, they are sampled on the active-to-idle edge. All four combinations capture correctly.
- R6: Bits are taken most significant first. Several consecutive bytes in one chip-select frame are each reported.
- R7: With compact_i 0, each pair is sent as four beats in this order: the MOSI byte, 0x28, the MISO byte, 0x29.
- R8: With compact_i 1, each pair is sent as two beats: the MOSI byte, then the MISO byte.
- R9: If a pair completes while the output register still holds an unfinished earlier pair, the new pair is dropped and overrun_o is set. overrun_o stays 1 until clr_i is 1.
- R10: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_data_o stays unchanged.
- R11: With en_i 0, the block disarms and reports nothing. Bits clocked while en_i is 0 never reach the stream, even after en_i returns to 1 inside the same frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Monitor enable |
| cpol_i | input | 1 | Bus clock idle level |
| cpha_i | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| compact_i | input | 1 | 1: two-beat raw format, 0: four-beat framed format |
| clr_i | input | 1 | Clears the sticky flags |
| spi_sclk_i | input | 1 | Bus clock (observed) |
| spi_cs_ni | input | 1 | Bus chip-select, active low (observed) |
| spi_mosi_i | input | 1 | Master-to-slave data (observed) |
| spi_miso_i | input | 1 | Slave-to-master data (observed) |
| out_data_o | output | 8 | Stream byte |
| out_valid_o | output | 1 | Stream byte valid |
| out_ready_i | input | 1 | Stream consumer ready |
| short_o | output | 1 | Sticky aborted-partial-byte flag |
| overrun_o | output | 1 | Sticky dropped-pair flag |

## Verification
A wrong bit count or wrong arming shows at the ports in one of two ways: stray or missing beats within one byte time of the bus, or bytes whose bits are rotated. The reference model catches either on the first beat that differs. A wrong sample edge gives bytes shifted by one bit, so the bench runs the same traffic in all four clock modes. Formatter state errors show as a missing or misplaced parenthesis, or as a beat that changes while the consumer stalls, on the very next handshake.

// File: rtl/spi_sniff_pkg.sv
package spi_sniff_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] OPEN_CODE  = 8'h28;
  localparam logic [BYTE_W-1:0] CLOSE_CODE = 8'h29;

  typedef struct packed {
    logic [BYTE_W-1:0] mosi;
    logic [BYTE_W-1:0] miso;
  } pair_t;
endpackage

// File: rtl/spi_sniff_sync.sv
module spi_sniff_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= RST_V;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/spi_sniff_capture.sv
module spi_sniff_capture
  import spi_sniff_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  cpol_i,
  input  logic  cpha_i,
  input  logic  clr_i,
  input  logic  sclk_i,
  input  logic  cs_ni,
  input  logic  mosi_i,
  input  logic  miso_i,
  output pair_t pair_o,
  output logic  pair_vld_o,
  output logic  short_o
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic          sclk_q, cs_q, armed_q, short_q;
  logic [CW-1:0] cnt_q;
  pair_t         sh_q;
  logic          cs_fall, cs_rise, samp;

  assign cs_fall = cs_q & ~cs_ni;
  assign cs_rise = ~cs_q & cs_ni;
  // sample on leading edge (line leaves idle) unless cpha selects trailing
  assign samp = (sclk_q ^ sclk_i) & ((sclk_i ^ cpol_i) ^ cpha_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      armed_q    <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      pair_o     <= '0;
      pair_vld_o <= 1'b0;
      short_q    <= 1'b0;
    end else begin
      sclk_q     <= sclk_i;
      cs_q       <= cs_ni;
      pair_vld_o <= 1'b0;
      if (clr_i) short_q <= 1'b0;
      if (!en_i) begin
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (cs_fall) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
        sh_q    <= '0;
      end else if (cs_rise) begin
        if (armed_q && cnt_q != '0) short_q <= 1'b1;
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else if (armed_q && samp) begin
        sh_q.mosi <= {sh_q.mosi[BYTE_W-2:0], mosi_i};
        sh_q.miso <= {sh_q.miso[BYTE_W-2:0], miso_i};
        if (cnt_q == CW'(BYTE_W-1)) begin
          cnt_q       <= '0;
          pair_vld_o  <= 1'b1;
          pair_o.mosi <= {sh_q.mosi[BYTE_W-2:0], mosi_i};
          pair_o.miso <= {sh_q.miso[BYTE_W-2:0], miso_i};
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign short_o = short_q;

  p_pair_needs_arm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_vld_o |-> $past(armed_q));
  p_cnt_idle_unarmed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || cs_fall || cs_rise) |=> cnt_q == '0);
  p_short_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (short_q && !clr_i) |=> short_q);
  p_disarm_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !armed_q);
endmodule

// File: rtl/spi_sniff_fmt.sv
module spi_sniff_fmt
  import spi_sniff_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              compact_i,
  input  logic              clr_i,
  input  pair_t             pair_i,
  input  logic              pair_vld_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic              ovr_o
);
  logic       busy_q, cmp_q, ovr_q;
  logic [1:0] idx_q;
  pair_t      hold_q;
  logic       fire, last, take;

  assign fire = busy_q & ready_i;
  assign last = cmp_q ? (idx_q == 2'd1) : (idx_q == 2'd3);
  assign take = pair_vld_i & (~busy_q | (fire & last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cmp_q  <= 1'b0;
      idx_q  <= '0;
      hold_q <= '0;
      ovr_q  <= 1'b0;
    end else begin
      if (take) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        cmp_q  <= compact_i;
        hold_q <= pair_i;
      end else if (fire && last) begin
        busy_q <= 1'b0;
      end else if (fire) begin
        idx_q <= idx_q + 1'b1;
      end
      if (clr_i) ovr_q <= 1'b0;
      else if (pair_vld_i && !take) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    if (cmp_q) data_o = idx_q[0] ? hold_q.miso : hold_q.mosi;
    else begin
      unique case (idx_q)
        2'd0:    data_o = hold_q.mosi;
        2'd1:    data_o = OPEN_CODE;
        2'd2:    data_o = hold_q.miso;
        default: data_o = CLOSE_CODE;
      endcase
    end
  end

  assign valid_o = busy_q;
  assign ovr_o   = ovr_q;

  p_hold_stall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));
  p_ovr_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !clr_i) |=> ovr_q);
  p_compact_two_beats_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && cmp_q) |-> idx_q <= 2'd1);
endmodule

// File: rtl/spi_sniff_framer.sv
module spi_sniff_framer
  import spi_sniff_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              compact_i,
  input  logic              clr_i,
  input  logic              spi_sclk_i,
  input  logic              spi_cs_ni,
  input  logic              spi_mosi_i,
  input  logic              spi_miso_i,
  output logic [BYTE_W-1:0] out_data_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              short_o,
  output logic              overrun_o
);
  logic [3:0] bus_s;
  pair_t      pair;
  logic       pair_vld;

  // order: sclk, cs_n, mosi, miso; cs resets inactive
  spi_sniff_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_V(4'b0100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({spi_sclk_i, spi_cs_ni, spi_mosi_i, spi_miso_i}),
    .q_o   (bus_s)
  );

  spi_sniff_capture u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .cpol_i    (cpol_i),
    .cpha_i    (cpha_i),
    .clr_i     (clr_i),
    .sclk_i    (bus_s[3]),
    .cs_ni     (bus_s[2]),
    .mosi_i    (bus_s[1]),
    .miso_i    (bus_s[0]),
    .pair_o    (pair),
    .pair_vld_o(pair_vld),
    .short_o   (short_o)
  );

  spi_sniff_fmt u_fmt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .compact_i (compact_i),
    .clr_i     (clr_i),
    .pair_i    (pair),
    .pair_vld_i(pair_vld),
    .data_o    (out_data_o),
    .valid_o   (out_valid_o),
    .ready_i   (out_ready_i),
    .ovr_o     (overrun_o)
  );

  p_quiet_after_reset_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!out_valid_o && !short_o && !overrun_o));
endmodule

// File: tb/sim_spi_sniff_framer.sv
module sim_spi_sniff_framer;
  localparam int CLK_T = 10;
  localparam int HALF  = 4;

  logic clk = 0, rst_n = 0;
  logic en = 0, cpol = 0, cpha = 0, compact = 0, clr = 0;
  logic sclk = 0, cs_n = 1, mosi = 0, miso = 0, ready = 1;
  logic [7:0] odata;
  logic ovalid, short_f, ovr_f;

  int vec = 0, bad = 0, cyc = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_T/2) clk = ~clk;

  spi_sniff_framer u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .compact_i(compact), .clr_i(clr), .spi_sclk_i(sclk), .spi_cs_ni(cs_n),
    .spi_mosi_i(mosi), .spi_miso_i(miso), .out_data_o(odata),
    .out_valid_o(ovalid), .out_ready_i(ready), .short_o(short_f),
    .overrun_o(ovr_f)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // stream monitor: every handshake compared against the model queue
  always @(negedge clk) begin
    if (rst_n && ovalid) begin
      if (exp_q.size() == 0) chk(1'b0, "stray beat", odata, 0);
      else if (ready) begin
        chk(odata == exp_q[0], tag_q[0], odata, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_pair(input logic [7:0] mo, input logic [7:0] mi, input string tag);
    exp_q.push_back(mo); tag_q.push_back(tag);
    if (!compact) begin exp_q.push_back(8'h28); tag_q.push_back({tag, " R7 open"}); end
    exp_q.push_back(mi); tag_q.push_back(tag);
    if (!compact) begin exp_q.push_back(8'h29); tag_q.push_back({tag, " R7 close"}); end
  endtask

  task automatic shift_bits(input logic [7:0] mo, input logic [7:0] mi, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      if (!cpha) begin mosi = mo[i]; miso = mi[i]; end
      wclk(HALF);
      sclk = ~cpol;
      if (cpha) begin mosi = mo[i]; miso = mi[i]; end
      wclk(HALF);
      sclk = cpol;
    end
  endtask

  task automatic cs_low();  cs_n = 0; wclk(HALF); endtask
  task automatic cs_high(); wclk(HALF); cs_n = 1; wclk(HALF); endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 300 && exp_q.size() > 0; i++) wclk(1);
    wclk(4);
    chk(exp_q.size() == 0 && !ovalid, tag, exp_q.size(), 0);
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sclk = p; wclk(8);
  endtask

  initial begin
    wclk(3);
    chk(!ovalid && !short_f && !ovr_f, "R1 reset outputs", {ovalid, short_f, ovr_f}, 0);
    rst_n = 1;
    wclk(3);
    chk(!ovalid && !short_f && !ovr_f, "R1 after release", {ovalid, short_f, ovr_f}, 0);

    // R2: CS already low at enable -> nothing captured
    cs_n = 0; wclk(6); en = 1; wclk(4);
    shift_bits(8'hA5, 8'h3C, 8);
    shift_bits(8'h11, 8'h22, 8);
    cs_high();
    drain("R2 no capture without CS edge");
    chk(!short_f, "R2 no short flag when unarmed", short_f, 0);

    // R7/R5 mode 0 verbose
    cs_low(); push_pair(8'hA5, 8'h3C, "R7 verbose pair");
    shift_bits(8'hA5, 8'h3C, 8); cs_high();
    drain("R7 verbose drained");

    // R6 several bytes in one frame, msb first
    cs_low();
    push_pair(8'h81, 8'h01, "R6 byte0"); shift_bits(8'h81, 8'h01, 8);
    push_pair(8'h7E, 8'h80, "R6 byte1"); shift_bits(8'h7E, 8'h80, 8);
    cs_high();
    drain("R6 drained");

    // R4 short frame, then R3 resync
    cs_low(); shift_bits(8'hFF, 8'hFF, 3); cs_high(); wclk(6);
    chk(short_f == 1, "R4 short flag set", short_f, 1);
    cs_low(); push_pair(8'h40, 8'h3F, "R3 resync byte");
    shift_bits(8'h40, 8'h3F, 8); cs_high();
    drain("R3 drained");
    chk(short_f == 1, "R4 short sticky", short_f, 1);
    clr = 1; wclk(1); clr = 0; wclk(2);
    chk(short_f == 0, "R4 short cleared", short_f, 0);

    // R8 compact
    compact = 1;
    cs_low(); push_pair(8'h12, 8'h34, "R8 compact pair");
    shift_bits(8'h12, 8'h34, 8); cs_high();
    drain("R8 drained");

    // R5 all four clock modes
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      cs_low(); push_pair(8'hC3 ^ 8'(m), 8'h5A + 8'(m), "R5 clock mode");
      shift_bits(8'hC3 ^ 8'(m), 8'h5A + 8'(m), 8); cs_high();
      drain("R5 mode drained");
    end
    set_mode(0, 0);
    compact = 0;

    // R10 stall, R9 overrun
    ready = 0;
    cs_low(); push_pair(8'h9C, 8'h63, "R9 kept pair");
    shift_bits(8'h9C, 8'h63, 8);
    wclk(10);
    for (int i = 0; i < 3; i++) begin
      chk(ovalid && odata == 8'h9C, "R10 held under stall", odata, 8'h9C);
      wclk(3);
    end
    shift_bits(8'hEE, 8'hDD, 8); cs_high(); wclk(6);
    chk(ovr_f == 1, "R9 overrun set", ovr_f, 1);
    chk(odata == 8'h9C, "R10 data unchanged after drop", odata, 8'h9C);
    ready = 1;
    drain("R9 dropped pair absent");
    chk(ovr_f == 1, "R9 overrun sticky", ovr_f, 1);
    clr = 1; wclk(1); clr = 0; wclk(2);
    chk(ovr_f == 0, "R9 overrun cleared", ovr_f, 0);

    // R11 disable: disarm mid-frame, nothing reported
    cs_low(); shift_bits(8'hAA, 8'h55, 4);
    en = 0; wclk(2);
    shift_bits(8'hAA, 8'h55, 4);
    en = 1; wclk(2);
    shift_bits(8'h0F, 8'hF0, 8); cs_high();
    drain("R11 nothing after disarm");
    chk(!short_f, "R11 no short after disarm", short_f, 0);
    en = 0;
    cs_low(); shift_bits(8'h33, 8'h44, 8); cs_high();
    drain("R11 nothing while disabled");
    en = 1;
    cs_low(); push_pair(8'h5E, 8'hE5, "R11 re-enabled pair");
    shift_bits(8'h5E, 8'hE5, 8); cs_high();
    drain("R11 re-enable drained");

    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule